// File: doc/BRIEF.md
# Sixteen-bit timer with coherent byte-wide readout

This block is a 16-bit up-counter that software reaches through a narrow 8-bit register port. Four byte addresses give the low byte, the high byte and a control/status byte. The count is advanced either once per system clock or once per rising edge of an external count input. That input can be passed through a two-stage resynchronizer before its edge is detected, or its edge can be detected straight from the raw pin sample, which gives less latency.

A 16-bit count cannot be read atomically over an 8-bit port, so a wide-access mode is provided. In that mode a read strobe on the low byte also takes a snapshot of the high byte into a holding register, and later reads of the high byte return that snapshot. The low and high halves then form one value from the same clock. Writes are staged the other way round: the high byte waits in a staging register and both halves enter the counter together on the low-byte write. The snapshot is taken the same way whichever count source is selected. With wide access turned off, both halves are read and written directly.

A wrap of the count from all ones to zero sets a sticky overflow flag. The flag drives the interrupt output and stays set until software clears it.

Top module: `tmr16_atomic`

## Requirements
- R1: After reset the count, staging and snapshot registers, the control byte and the overflow flag are all zero. While the run bit (control bit 0) is clear and no register is written, the count holds.
- R2: With run set and the source bit (control bit 1) clear, the count grows by one on every clock. Each increment can be read at address 0 (low byte) in the cycle after the edge that made it.
- R3: With the wide bit (control bit 3) set, a read strobe at address 0 copies the high byte of the count into the snapshot at that clock edge. A read at address 1 then returns the snapshot, so the pair of reads gives one coherent 16-bit value.
- R4: With the wide bit clear, a read at address 1 returns the live high byte of the count.
- R5: With the source bit set and the async bit (control bit 2) clear, the input passes two synchronizer flops before edge detection. The count rises at the third clock edge that samples the input high after a low sample, and only once per input pulse.
- R6: With the source bit and the async bit both set, the count rises at the first clock edge that samples the input high after a low sample.
- R7: The snapshot of R3 is taken on a low-byte read strobe in both external modes, synchronized and unsynchronized, while the count keeps advancing.
- R8: A wrap from 0xFFFF to 0x0000 sets the overflow flag, seen at control bit 7 and on `irq`. The flag stays set until a control write (address 2) with bit 7 at zero. A control write with bit 7 at one leaves it unchanged. A wrap in the same cycle as a clearing write leaves the flag set.
- R9: With the wide bit set, a write at address 1 goes into the staging register only, and the count keeps running. A write at address 0 loads {staging, data} into the count at once. A count write wins over an increment in the same cycle.
- R10: With the wide bit clear, writes at addresses 0 and 1 replace the low or high byte of the count directly, also while it runs. Control bits 6:4 and address 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_in | input | 1 | External count input |
| addr | input | 2 | Register address: 0 low, 1 high, 2 control |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (takes the wide-mode snapshot) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Overflow flag |

## Verification
Read data is combinational, so each register result is due in the cycle right after the edge that made it. A count-clock increment, a byte write, a snapshot and a flag change all appear one edge after their stimulus. External edges appear after one edge in unsynchronized mode and after three edges in synchronized mode. The bench drives every input on the falling edge. It advances a reference model at the rising edge and compares `rdata` and `irq` at the next falling edge, so every comparison lands on the cycle in which the result is due.

// File: rtl/tmr16_atomic.sv
module tmr16_atomic #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_in,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  output logic          irq
);
  localparam int CW = 2 * BW;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt;
  logic [BW-1:0] hbuf, hwbuf;
  logic run_en, src_ext, no_sync, wide, flag;
  logic [1:0] sy;
  logic sy_d, raw_d;
  logic tick, inc;
  logic wr_lo, wr_hi, wr_ctl, cnt_wr;

  assign wr_lo  = wr_en && addr == 2'd0;
  assign wr_hi  = wr_en && addr == 2'd1;
  assign wr_ctl = wr_en && addr == 2'd2;
  assign cnt_wr = wr_lo || (wr_hi && !wide);

  assign tick = no_sync ? (ext_in && !raw_d) : (sy[1] && !sy_d);
  assign inc  = run_en && (src_ext ? tick : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; hbuf <= '0; hwbuf <= '0;
      run_en <= 1'b0; src_ext <= 1'b0; no_sync <= 1'b0; wide <= 1'b0; flag <= 1'b0;
      sy <= '0; sy_d <= 1'b0; raw_d <= 1'b0;
    end else begin
      sy    <= {sy[0], ext_in};
      sy_d  <= sy[1];
      raw_d <= ext_in;
      if (wr_ctl) begin
        run_en  <= wdata[0];
        src_ext <= wdata[1];
        no_sync <= wdata[2];
        wide    <= wdata[3];
        if (!wdata[BW-1]) flag <= 1'b0;
      end
      if (wr_lo)              cnt <= wide ? {hwbuf, wdata} : {cnt[CW-1:BW], wdata};
      else if (wr_hi && !wide) cnt <= {wdata, cnt[BW-1:0]};
      else if (inc)           cnt <= cnt + 1'b1;
      if (wr_hi && wide) hwbuf <= wdata;
      if (inc && !cnt_wr && cnt == CMAX) flag <= 1'b1;
      if (rd_en && addr == 2'd0 && wide) hbuf <= cnt[CW-1:BW];
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = cnt[BW-1:0];
      2'd1:    rdata = wide ? hbuf : cnt[CW-1:BW];
      2'd2:    rdata = {flag, {(BW-5){1'b0}}, wide, no_sync, src_ext, run_en};
      default: rdata = '0;
    endcase
  end

  assign irq = flag;
endmodule

// File: rtl/tmr16_atomic_chk.sv
module tmr16_atomic_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [7:0]  wdata,
  input logic [15:0] cnt,
  input logic [7:0]  hbuf,
  input logic [7:0]  hwbuf,
  input logic        inc,
  input logic        flag,
  input logic        wide,
  input logic        run_en
);
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_en) |=> $stable(cnt)); // R1
  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && rd_en && addr == 2'd0) |=> hbuf == $past(cnt[15:8])); // R3
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en && cnt == 16'hFFFF) |=> (flag && cnt == 16'h0000)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && addr == 2'd2 && !wdata[7])) |=> flag); // R8
  AST_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && wr_en && addr == 2'd0) |=> cnt == {$past(hwbuf), $past(wdata)}); // R9
endmodule

bind tmr16_atomic tmr16_atomic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .cnt(cnt), .hbuf(hbuf), .hwbuf(hwbuf), .inc(inc),
  .flag(flag), .wide(wide), .run_en(run_en)
);

// File: tb/tmr16_atomic_test.sv
`timescale 1ns/1ps
module tmr16_atomic_test;
  logic clk = 1'b0, rst_n = 1'b0, ext_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic irq;
  int vectors = 0, errors = 0;

  always #2 clk = ~clk;

  tmr16_atomic uut (.clk(clk), .rst_n(rst_n), .ext_in(ext_in), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  logic [15:0] m_cnt;
  logic [7:0] m_hbuf, m_hw;
  logic m_run, m_src, m_async, m_wide, m_flag;
  logic e1, e2, e3, ep;

  task automatic m_reset();
    m_cnt = 0; m_hbuf = 0; m_hw = 0;
    m_run = 0; m_src = 0; m_async = 0; m_wide = 0; m_flag = 0;
    e1 = 0; e2 = 0; e3 = 0; ep = 0;
  endtask

  task automatic m_edge();
    logic tk, inc, cw, clr, setf;
    logic [15:0] c;
    tk  = m_async ? (ext_in && !ep) : (e2 && !e3);
    inc = m_run && (m_src ? tk : 1'b1);
    cw  = wr_en && (addr == 0 || (addr == 1 && !m_wide));
    c   = m_cnt;
    setf = inc && !cw && c == 16'hFFFF;
    clr  = wr_en && addr == 2 && !wdata[7];
    if (rd_en && addr == 0 && m_wide) m_hbuf = c[15:8];
    if (wr_en && addr == 0) m_cnt = m_wide ? {m_hw, wdata} : {c[15:8], wdata};
    else if (wr_en && addr == 1 && !m_wide) m_cnt = {wdata, c[7:0]};
    else if (inc) m_cnt = c + 1;
    if (wr_en && addr == 1 && m_wide) m_hw = wdata;
    if (clr) m_flag = 0;
    if (setf) m_flag = 1;
    if (wr_en && addr == 2) begin
      m_run = wdata[0]; m_src = wdata[1]; m_async = wdata[2]; m_wide = wdata[3];
    end
    e3 = e2; e2 = e1; e1 = ext_in; ep = ext_in;
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt[7:0];
      2'd1: return m_wide ? m_hbuf : m_cnt[15:8];
      2'd2: return {m_flag, 3'b000, m_wide, m_async, m_src, m_run};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] a, input logic w, input logic r,
                      input logic [7:0] d, input logic e, input string tag);
    addr = a; wr_en = w; rd_en = r; wdata = d; ext_in = e;
    @(posedge clk);
    if (rst_n) m_edge(); else m_reset();
    @(negedge clk);
    chk(rdata, exp_rd(a), tag);
    chk({7'd0, irq}, {7'd0, m_flag}, "R8");
  endtask

  task automatic idle(input logic [1:0] a, input int n, input string tag);
    for (int i = 0; i < n; i++) step(a, 0, 0, 8'h00, ext_in, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    m_reset();
    @(negedge clk);
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, "R1");
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R1");
    step(2, 0, 0, 0, 0, "R1");
    idle(1, 3, "R1");

    step(2, 1, 0, 8'h01, 0, "R2");
    idle(0, 5, "R2");
    step(0, 1, 0, 8'hF0, 0, "R10");
    step(1, 1, 0, 8'h3C, 0, "R10");
    idle(1, 2, "R4");
    idle(0, 20, "R4");
    idle(1, 2, "R4");
    step(3, 0, 0, 0, 0, "R10");

    step(2, 1, 0, 8'h09, 0, "R9");
    step(1, 1, 0, 8'h12, 0, "R9");
    idle(0, 2, "R9");
    step(0, 1, 0, 8'hFE, 0, "R9");
    step(0, 0, 1, 0, 0, "R3");
    step(0, 0, 1, 0, 0, "R3");
    step(1, 0, 0, 0, 0, "R3");
    idle(0, 3, "R3");
    step(1, 0, 0, 0, 0, "R3");

    step(1, 1, 0, 8'hFF, 0, "R9");
    step(0, 1, 0, 8'hFD, 0, "R9");
    idle(2, 4, "R8");
    step(2, 1, 0, 8'h89, 0, "R8");
    idle(2, 2, "R8");
    step(2, 1, 0, 8'h09, 0, "R8");
    step(2, 1, 0, 8'h08, 0, "R1");
    idle(0, 4, "R1");

    step(2, 1, 0, 8'h0B, 0, "R5");
    for (int p = 0; p < 6; p++) begin
      step(0, 0, 0, 0, 1, "R5");
      step(0, 0, 0, 0, 1, "R5");
      step(0, 0, 0, 0, 1, "R5");
      step(0, 0, 1, 0, 0, "R7");
      step(1, 0, 0, 0, 0, "R7");
    end
    step(2, 1, 0, 8'h0F, 0, "R6");
    for (int p = 0; p < 6; p++) begin
      step(0, 0, 0, 0, 1, "R6");
      step(0, 0, 1, 0, 0, "R7");
      step(1, 0, 0, 0, 1, "R7");
      step(0, 0, 0, 0, 0, "R6");
    end

    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      logic w;
      logic [7:0] d;
      a = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 9) == 0);
      d = 8'($urandom);
      if (w && a == 2 && $urandom_range(0, 3) != 0) d[7] = 1'b1;
      if (w && a == 0 && $urandom_range(0, 3) == 0) d = 8'hF8;
      step(a, w, $urandom_range(0, 1) == 1, d, $urandom_range(0, 2) == 0,
           a == 0 ? "R2" : a == 1 ? "R3" : "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule